// File: doc/BRIEF.md
# Interleaved Memory Bank Scheduler

This block stands between a requester and a main memory split into sixteen interleaved banks. Each cycle it takes at most one read or write request, carrying a 20-bit word address and a 72-bit word. The low address bits pick the bank, and the upper bits pick the word inside that bank. After a bank accepts an access it stays occupied for a fixed recovery time of four cycles. A request that targets an occupied bank is held off with backpressure until the bank recovers. Requests to other banks can still be accepted at one per cycle.

The requester must keep a stalled request stable until it is accepted, so requests issue strictly in order. Each read returns its word a fixed two cycles after acceptance, marked by a valid strobe. A write returns nothing. The 72-bit word holds 64 data bits and 8 check bits. The block stores and returns all 72 bits unchanged and never computes or checks the check bits. The bank arrays are behavioural models. Each model keeps only the low `MODEL_ROW_W` bits of the in-bank word index, so the storage stays small when the design is elaborated.

Top module: `ilv_mem_sched`

## Requirements
- R1: After reset every bank is free, `req_ready` is high for any address, and `rsp_valid` is low.
- R2: The bank index is `req_addr[3:0]` and the word inside the bank is `req_addr[19:4]`. Addresses that differ only in the bank bits go to different banks and never overwrite each other.
- R3: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low exactly when the addressed bank accepted an access in one of the previous three cycles.
- R4: After a bank accepts an access, the next access to that same bank is accepted no earlier than four cycles later.
- R5: A unit-stride stream (consecutive addresses) is accepted at one request per cycle, with no stall.
- R6: A stride-16 stream (every request to the same bank) is accepted at one request per four cycles, with three stall cycles between accepts.
- R7: A read accepted in cycle k drives `rsp_valid` high for exactly one cycle, in cycle k+2.
- R8: An accepted write produces no response, and `rsp_valid` stays low for it.
- R9: All 72 bits written to an address, including the top 8 check bits, are returned unchanged by a later read of that address.
- R10: A stalled request is held stable by the requester until it is accepted. Responses come back in the order the reads were accepted.
- R11: A request to a free bank is accepted at once, even while other banks are busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address; bank in the low 4 bits |
| req_wdata | input | 72 | Word to store (64 data + 8 check bits) |
| req_ready | output | 1 | Addressed bank is free; request accepted this cycle if valid |
| rsp_valid | output | 1 | Read data is present on `rsp_rdata` |
| rsp_rdata | output | 72 | Returned word |

## Verification
The bench builds the block with its default parameters: sixteen banks, a four-cycle recovery, a two-cycle read latency and six modelled row bits. With these values one 64-row window per bank is enough to write and read back whole unit-stride and stride-16 streams. The exact three-cycle stall of a same-bank pair is visible, and so is the zero-cycle issue to a neighbouring bank while another bank is still busy. Rows up to 63 are reachable, so two addresses that share a row and differ only in their bank bits can be used to show that the bank decode keeps them apart.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;

   // Width of a counter that must hold values 0 .. n-1, never below one bit.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer
   import ilv_mem_pkg::*;
#(
   parameter int unsigned BUSY_CYC = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   generate
      if (BUSY_CYC <= 1) begin : g_no_recovery
         // A bank that recovers in one cycle is never seen busy.
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ start;
         assign busy      = 1'b0;
      end else begin : g_down_count
         localparam int unsigned CW = cnt_width(BUSY_CYC);
         localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC - 1);
         logic [CW-1:0] remain;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               remain <= '0;
            else if (start)
               remain <= LOAD;
            else if (remain != '0)
               remain <= remain - 1'b1;
         end

         assign busy = (remain != '0);
      end
   endgenerate

endmodule

// File: rtl/ilv_bank_store.sv
module ilv_bank_store #(
   parameter int unsigned WORD_W = 72,
   parameter int unsigned ROW_W  = 6
)(
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ROW_W-1:0]  row,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);

   localparam int unsigned ROWS = 1 << ROW_W;

   logic [WORD_W-1:0] cells [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en)
         cells[row] <= wdata;
      if (rd_en)
         rdata <= cells[row];
   end

endmodule

// File: rtl/ilv_rd_return.sv
module ilv_rd_return #(
   parameter int unsigned WORD_W = 72,
   parameter int unsigned STAGES = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data
);

   generate
      if (STAGES == 0) begin : g_direct
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign out_valid = in_valid;
         assign out_data  = in_data;
      end else begin : g_pipe
         logic [STAGES-1:0] vld;
         logic [WORD_W-1:0] dat [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld <= '0;
            end else begin
               vld[0] <= in_valid;
               for (int i = 1; i < STAGES; i++)
                  vld[i] <= vld[i-1];
            end
         end

         always_ff @(posedge clk) begin
            dat[0] <= in_data;
            for (int i = 1; i < STAGES; i++)
               dat[i] <= dat[i-1];
         end

         assign out_valid = vld[STAGES-1];
         assign out_data  = dat[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ilv_mem_sched.sv
module ilv_mem_sched
   import ilv_mem_pkg::*;
#(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned NUM_BANKS   = 16,
   parameter int unsigned WORD_W      = 72,
   parameter int unsigned BUSY_CYC    = 4,
   parameter int unsigned RD_LAT      = 2,
   parameter int unsigned MODEL_ROW_W = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata
);

   localparam int unsigned BANK_W = $clog2(NUM_BANKS);
   localparam int unsigned ROW_W  = ADDR_W - BANK_W;

   // Elaboration-time parameter checks
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (ADDR_W <= BANK_W) begin : g_bad_addr
      $error("ADDR_W must leave row bits above the bank bits");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least 1");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end
   if (MODEL_ROW_W < 1 || MODEL_ROW_W > ROW_W) begin : g_bad_model
      $error("MODEL_ROW_W must lie in 1 .. row width");
   end

   // Address split: bank in the low bits so that consecutive words interleave
   logic [BANK_W-1:0]      req_bank;
   logic [ROW_W-1:0]       req_row;
   logic [MODEL_ROW_W-1:0] mem_row;

   assign req_bank = req_addr[BANK_W-1:0];
   assign req_row  = req_addr[ADDR_W-1:BANK_W];
   assign mem_row  = req_row[MODEL_ROW_W-1:0];

   if (MODEL_ROW_W < ROW_W) begin : g_row_trunc
      logic unused_row_hi;
      assign unused_row_hi = ^req_row[ROW_W-1:MODEL_ROW_W];
   end

   // Issue decision
   logic [NUM_BANKS-1:0] bank_busy;
   logic                 accept;
   logic                 rd_accept;
   logic [WORD_W-1:0]    bank_q [NUM_BANKS];

   assign req_ready = ~bank_busy[req_bank];
   assign accept    = req_valid & req_ready;
   assign rd_accept = accept & ~req_write;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = accept && (req_bank == BANK_W'(b));

      ilv_bank_timer #(
         .BUSY_CYC (BUSY_CYC)
      ) u_timer (
         .clk   (clk),
         .rst_n (rst_n),
         .start (hit),
         .busy  (bank_busy[b])
      );

      ilv_bank_store #(
         .WORD_W (WORD_W),
         .ROW_W  (MODEL_ROW_W)
      ) u_store (
         .clk   (clk),
         .wr_en (hit & req_write),
         .rd_en (hit & ~req_write),
         .row   (mem_row),
         .wdata (req_wdata),
         .rdata (bank_q[b])
      );
   end

   // First return stage: the bank arrays read on the accept edge
   logic              s0_valid;
   logic [BANK_W-1:0] s0_bank;
   logic [WORD_W-1:0] s0_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0_valid <= 1'b0;
         s0_bank  <= '0;
      end else begin
         s0_valid <= rd_accept;
         if (rd_accept)
            s0_bank <= req_bank;
      end
   end

   assign s0_data = bank_q[s0_bank];

   ilv_rd_return #(
      .WORD_W (WORD_W),
      .STAGES (RD_LAT - 1)
   ) u_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s0_valid),
      .in_data   (s0_data),
      .out_valid (rsp_valid),
      .out_data  (rsp_rdata)
   );

endmodule

// File: rtl/ilv_mem_sched_chk.sv
module ilv_mem_sched_chk
   import ilv_mem_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned NUM_BANKS = 16,
   parameter int unsigned BUSY_CYC  = 4,
   parameter int unsigned RD_LAT    = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_ready,
   input logic              rsp_valid
);

   localparam int unsigned BANK_W = $clog2(NUM_BANKS);
   localparam int unsigned SW     = cnt_width(BUSY_CYC);
   localparam logic [SW-1:0] SAT  = SW'(BUSY_CYC - 1);

   logic [BANK_W-1:0]    bank;
   logic                 take;
   logic [NUM_BANKS-1:0] idle_vec;
   logic                 unused_hi;

   assign bank      = req_addr[BANK_W-1:0];
   assign take      = req_valid & req_ready;
   assign unused_hi = ^req_addr[ADDR_W-1:BANK_W];

   // Cycles since each bank last accepted, saturating at BUSY_CYC-1
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_age
      logic [SW-1:0] age;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            age <= SAT;
         else if (take && bank == BANK_W'(b))
            age <= '0;
         else if (age != SAT)
            age <= age + 1'b1;
      end
      assign idle_vec[b] = (age == SAT);

      AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         (take && bank == BANK_W'(b)) |-> (age == SAT))
         else $error("same bank accepted inside its recovery window"); // R4
   end

   // Shift record of accepted reads
   logic [RD_LAT-1:0] rd_hist;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_hist <= '0;
      end else begin
         rd_hist[0] <= take & ~req_write;
         for (int i = 1; i < RD_LAT; i++)
            rd_hist[i] <= rd_hist[i-1];
      end
   end

   AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && idle_vec[bank]) |-> req_ready)
      else $error("free bank refused"); // R11

   AST_STALL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !idle_vec[bank]) |-> !req_ready)
      else $error("busy bank not stalled"); // R3

   AST_RSP_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == rd_hist[RD_LAT-1])
      else $error("response strobe does not match accepted reads"); // R7

   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)))
      else $error("stalled request changed"); // R10

endmodule

bind ilv_mem_sched ilv_mem_sched_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_BANKS (NUM_BANKS),
   .BUSY_CYC  (BUSY_CYC),
   .RD_LAT    (RD_LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid)
);

// File: tb/ilv_mem_sched_tb.sv
`timescale 1ns/1ps
module ilv_mem_sched_tb;

   localparam int AW = 20;
   localparam int WW = 72;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [WW-1:0] req_wdata = '0;
   logic          req_ready;
   logic          rsp_valid;
   logic [WW-1:0] rsp_rdata;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int rsp_seen = 0;
   int last_edge = 0;
   int prev_edge = 0;
   int last_stall = 0;
   bit mon_on = 1'b0;

   typedef struct {
      logic [WW-1:0] data;
      int            due;
   } exp_t;

   exp_t          sb[$];
   logic [WW-1:0] ref_mem [int];

   ilv_mem_sched u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] mk(logic [AW-1:0] a, logic [7:0] salt);
      return {8'hF0 ^ a[7:0] ^ salt, 32'hDEAD0000 + 32'(a), 32'(a) * 32'd3 + 32'(salt)};
   endfunction

   // Driver: presents one request, holds it through any stall, records expectations
   task automatic issue(bit wr, logic [AW-1:0] a, logic [WW-1:0] d);
      req_valid  = 1'b1;
      req_write  = wr;
      req_addr   = a;
      req_wdata  = d;
      last_stall = 0;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
         last_stall++;
      end
      prev_edge = last_edge;
      last_edge = cyc + 1;
      if (wr) begin
         ref_mem[int'(a)] = d;
      end else begin
         exp_t e;
         e.data = ref_mem[int'(a)];
         e.due  = cyc + 2;
         sb.push_back(e);
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(int n);
      req_valid = 1'b0;
      req_write = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops the scoreboard as responses appear
   always @(negedge clk) begin
      if (mon_on) begin
         if (rsp_valid) begin
            rsp_seen++;
            if (sb.size() == 0) begin
               chk(1'b0, "R8", "response with none expected", rsp_rdata, '0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(rsp_rdata === e.data, "R9", "returned word", rsp_rdata, e.data);
               chk(cyc == e.due, "R7", "response cycle", WW'(cyc), WW'(e.due));
            end
         end else if (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk(1'b0, "R7", "missing response", '0, e.data);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seen0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);

      // R1: reset state
      req_valid = 1'b1;
      req_addr  = 20'h00005;
      #1;
      chk(req_ready === 1'b1, "R1", "ready after reset", WW'(req_ready), 1);
      chk(rsp_valid === 1'b0, "R1", "no response after reset", WW'(rsp_valid), 0);
      req_valid = 1'b0;
      @(negedge clk);

      // R5 / R8: unit-stride writes, one per cycle, no response
      seen0 = rsp_seen;
      for (int i = 0; i < 16; i++) begin
         issue(1'b1, AW'(48 + i), mk(AW'(48 + i), 8'h11));
         if (i > 0) chk(last_edge - prev_edge == 1, "R5", "unit-stride write gap", WW'(last_edge - prev_edge), 1);
      end
      idle(5);
      chk(rsp_seen == seen0, "R8", "writes produced responses", WW'(rsp_seen - seen0), 0);

      // R5 / R9 / R10: unit-stride reads back, in order
      for (int i = 0; i < 16; i++) begin
         issue(1'b0, AW'(48 + i), '0);
         if (i > 0) chk(last_edge - prev_edge == 1, "R5", "unit-stride read gap", WW'(last_edge - prev_edge), 1);
         chk(last_stall == 0, "R5", "unit-stride stall", WW'(last_stall), 0);
      end
      idle(5);

      // R6 / R4: stride-16 writes to bank 7, then reads
      for (int r = 0; r < 6; r++) begin
         issue(1'b1, AW'(r * 16 + 7), mk(AW'(r * 16 + 7), 8'h5A));
         if (r > 0) begin
            chk(last_edge - prev_edge == 4, "R6", "stride-16 write gap", WW'(last_edge - prev_edge), 4);
            chk(last_stall == 3, "R4", "stride-16 stall cycles", WW'(last_stall), 3);
         end
      end
      for (int r = 0; r < 6; r++) begin
         issue(1'b0, AW'(r * 16 + 7), '0);
         chk(last_edge - prev_edge == 4, "R6", "stride-16 read gap", WW'(last_edge - prev_edge), 4);
      end
      idle(6);

      // R11 / R3: other bank issues while bank 2 is busy; bank 2 stalls
      issue(1'b1, 20'h00012, {8'hFF, 64'h0123_4567_89AB_CDEF});
      issue(1'b0, AW'(53), '0);
      chk(last_stall == 0, "R11", "free bank stalled", WW'(last_stall), 0);
      chk(last_edge - prev_edge == 1, "R11", "free bank gap", WW'(last_edge - prev_edge), 1);
      issue(1'b0, 20'h00012, '0);
      chk(last_stall == 2, "R3", "busy bank stall cycles", WW'(last_stall), 2);
      idle(6);

      // R2: bank decode on the low bits, row on the upper bits
      issue(1'b1, AW'(1007), mk(AW'(1007), 8'h77));
      issue(1'b1, AW'(1023), {8'hC3, 64'hFEED_FACE_0000_1111});
      chk(last_stall == 3, "R2", "same bank (15) stall", WW'(last_stall), 3);
      issue(1'b1, AW'(1008), {8'h3C, 64'h0F0F_0F0F_F0F0_F0F0});
      chk(last_stall == 0, "R2", "other bank (0) stall", WW'(last_stall), 0);
      issue(1'b0, AW'(1023), '0);
      issue(1'b0, AW'(1008), '0);
      issue(1'b0, AW'(1007), '0);
      idle(8);

      chk(sb.size() == 0, "R7", "responses outstanding at end", WW'(sb.size()), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule